// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns one read on the system bus into one complete serial flash read. The window decode upstream supplies the chip-select index, the byte offset inside that chip's window and the access size (1, 2 or 4 bytes). It also supplies the control word of that chip select and the register of per-select address-width flags. The engine lowers the chosen chip select and shifts out the read opcode. It then sends the address, as three or four bytes, followed by any 0xFF dummy bytes. Next it clocks in the requested bytes, raises the chip select and keeps it high for a programmed gap. Only after the gap can the next read start.

The control word gives the opcode in bits 23:16 and the access mode in bits 1:0. Mode 0 is a plain read and mode 1 is a fast read. The 3-bit dummy count sits in bits 14 (high bit) and 7:6 (low bits). The gap field sits in bits 27:24. A request that names another mode, or a chip select the block does not have, completes at once with an error flag and makes no serial traffic.

The sequencer is a state machine with the states IDLE, CMD, ADDR, DUMMY, DATA and GAP. IDLE goes to CMD when a valid request is accepted and stays in IDLE when a request is rejected. CMD goes to ADDR after the opcode byte. ADDR goes to DUMMY after its last byte when the dummy count is non-zero, and to DATA otherwise. DUMMY goes to DATA after its last dummy byte. DATA goes to GAP after the last data byte. GAP returns to IDLE when its countdown reaches one.

Top module: `flash_rd_engine`

## Requirements
- R1: After reset all chip-select outputs are high, the serial clock is low, no response is signalled and `req_ready` is high.
- R2: An accepted read drives exactly one chip-select line low, the one given by `req_cs`. The first byte sent while it is low is the opcode from control bits 23:16.
- R3: In mode 0 (control bits 1:0 = 0) no dummy bytes are sent, whatever the dummy field holds. The first data byte follows straight after the last address byte.
- R4: In mode 1 the number of dummy bytes sent after the address is {bit 14, bits 7:6} of the control word, and every dummy byte is 0xFF. A count of zero sends none.
- R5: Bit k of `addr4_mask` selects the address width for chip select k. When it is 1, all four offset bytes are sent, most significant first. When it is 0, only bits 23:0 are sent as three bytes, most significant first, and offset bits 31:24 are ignored.
- R6: `req_size` 0 reads 1 byte, 1 reads 2 bytes, and 2 or 3 read 4 bytes. Exactly that many data bytes are clocked. The first byte received lands in `resp_data[7:0]`, the next bytes fill the following byte lanes (little-endian), and unused lanes read zero.
- R7: A request with mode 2 or 3, or with `req_cs` at or above NUM_CS, gets a one-cycle response with `resp_err` = 1 and `resp_data` = 0 on the cycle after acceptance. No chip select is lowered for it.
- R8: After the last data byte the chip select goes high and stays high for at least 16 − (control bits 27:24) cycles before any chip select goes low again.
- R9: The serial link uses clock mode 0. The clock idles low, data out is sent MSB first and changes while the clock is low, and data in is sampled when the clock rises. Each accepted request yields exactly one single-cycle `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Control word of the addressed chip select |
| addr4_mask | input | NUM_CS | Per-chip-select 4-byte address enable |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_cs | input | CS_W | Chip-select index of the read |
| req_offset | input | 32 | Byte offset inside the chip's window |
| req_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request was rejected |
| resp_data | output | 32 | Read data, little-endian packed |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The flash model in the bench decodes the address it receives and answers with bytes derived from that address. A wrong address, dropped or extra header bytes, or wrong byte ordering therefore shows up both in the recorded header and in the returned data. The bench sweeps three-byte and four-byte addressing, including an offset with set upper bits that must not reach the wire. It covers mode 0 with a non-zero dummy field, which must send no dummies, and mode 1 with dummy counts of 0, 1 and 5. All four size codes are used. Rejected modes and an out-of-range chip select are checked for silence on the chip selects. Back-to-back reads with two gap settings check that the chip select stays high long enough.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_GAP
    } rd_state_e;

    // control word field positions
    localparam int OPC_LSB    = 16;
    localparam int GAP_LSB    = 24;
    localparam int DUMHI_BIT  = 14;
    localparam int DUMLO_LSB  = 6;
    localparam int MODE_LSB   = 0;

    localparam logic [1:0] MODE_PLAIN = 2'd0;
    localparam logic [1:0] MODE_FAST  = 2'd1;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/flash_rd_decode.sv
module flash_rd_decode
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [31:0]       ctrl_word,
    input  logic [NUM_CS-1:0] addr4_mask,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [1:0]        req_size,
    output logic [7:0]        opcode,
    output logic              accept_ok,
    output logic [3:0]        n_dummy,
    output logic [3:0]        n_addr,
    output logic [3:0]        n_data,
    output logic [4:0]        gap_cycles,
    output logic [NUM_CS-1:0] cs_hot
);

    logic [1:0] mode;
    logic       wide_addr;
    logic       cs_in_range;
    logic       unused_ctrl;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_hot[g] = (req_cs == CS_W'(g));
    end

    assign cs_in_range = |cs_hot;
    assign wide_addr   = |(cs_hot & addr4_mask);
    assign mode        = ctrl_word[MODE_LSB +: 2];
    assign opcode      = ctrl_word[OPC_LSB +: 8];
    assign accept_ok   = cs_in_range && (mode == MODE_PLAIN || mode == MODE_FAST);
    assign n_dummy     = (mode == MODE_FAST)
                         ? {1'b0, ctrl_word[DUMHI_BIT], ctrl_word[DUMLO_LSB +: 2]}
                         : 4'd0;
    assign n_addr      = wide_addr ? 4'd4 : 4'd3;
    assign n_data      = size_to_bytes(req_size);
    assign gap_cycles  = 5'd16 - {1'b0, ctrl_word[GAP_LSB +: 4]};

    assign unused_ctrl = ^{ctrl_word[31:28], ctrl_word[15], ctrl_word[13:8], ctrl_word[5:2]};

endmodule

// File: rtl/flash_rd_shifter.sv
module flash_rd_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    logic       busy;
    logic       phase;
    logic [2:0] bit_left;
    logic [7:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            bit_left <= 3'd0;
            tx_q     <= 8'd0;
            rx_byte  <= 8'd0;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go && !done) begin
                    busy     <= 1'b1;
                    phase    <= 1'b0;
                    bit_left <= 3'd7;
                    tx_q     <= tx_byte;
                    mosi     <= tx_byte[7];
                end
            end else if (!phase) begin
                sclk    <= 1'b1;
                rx_byte <= {rx_byte[6:0], miso};
                phase   <= 1'b1;
            end else begin
                sclk  <= 1'b0;
                phase <= 1'b0;
                if (bit_left == 3'd0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_left <= bit_left - 3'd1;
                    tx_q     <= {tx_q[6:0], 1'b0};
                    mosi     <= tx_q[6];
                end
            end
        end
    end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_offset,
    input  logic [7:0]        opcode,
    input  logic              accept_ok,
    input  logic [3:0]        n_dummy,
    input  logic [3:0]        n_addr,
    input  logic [3:0]        n_data,
    input  logic [4:0]        gap_cycles,
    input  logic [NUM_CS-1:0] cs_hot,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              req_ready,
    output logic              sh_go,
    output logic [7:0]        sh_tx,
    output logic [NUM_CS-1:0] cs_n,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [31:0]       resp_data
);

    rd_state_e   state_q, state_d;
    logic [3:0]  idx_q;
    logic [7:0]  op_q;
    logic [31:0] addr_q;
    logic [3:0]  naddr_q, ndum_q, ndata_q;
    logic [4:0]  gap_q;
    logic        last_addr, last_dummy, last_data;

    assign last_addr  = (idx_q == naddr_q - 4'd1);
    assign last_dummy = (idx_q == ndum_q - 4'd1);
    assign last_data  = (idx_q == ndata_q - 4'd1);
    assign req_ready  = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid && accept_ok) state_d = ST_CMD;
            ST_CMD:   if (sh_done) state_d = ST_ADDR;
            ST_ADDR:  if (sh_done && last_addr)
                          state_d = (ndum_q != 4'd0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (sh_done && last_dummy) state_d = ST_DATA;
            ST_DATA:  if (sh_done && last_data) state_d = ST_GAP;
            ST_GAP:   if (gap_q == 5'd1) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // byte to shift
    always_comb begin
        sh_go = 1'b0;
        sh_tx = 8'hFF;
        unique case (state_q)
            ST_CMD: begin
                sh_go = 1'b1;
                sh_tx = op_q;
            end
            ST_ADDR: begin
                sh_go = 1'b1;
                sh_tx = 8'(addr_q >> {(naddr_q - 4'd1 - idx_q), 3'b000});
            end
            ST_DUMMY, ST_DATA: sh_go = 1'b1;
            default: ;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= 4'd0;
            op_q       <= 8'd0;
            addr_q     <= 32'd0;
            naddr_q    <= 4'd3;
            ndum_q     <= 4'd0;
            ndata_q    <= 4'd1;
            gap_q      <= 5'd0;
            cs_n       <= '1;
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_data  <= 32'd0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    resp_data <= 32'd0;
                    idx_q     <= 4'd0;
                    if (accept_ok) begin
                        op_q    <= opcode;
                        naddr_q <= n_addr;
                        addr_q  <= (n_addr == 4'd4) ? req_offset : {8'd0, req_offset[23:0]};
                        ndum_q  <= n_dummy;
                        ndata_q <= n_data;
                        gap_q   <= gap_cycles;
                        cs_n    <= ~cs_hot;
                    end else begin
                        resp_valid <= 1'b1;
                        resp_err   <= 1'b1;
                    end
                end
                ST_CMD: if (sh_done) idx_q <= 4'd0;
                ST_ADDR: if (sh_done) idx_q <= last_addr ? 4'd0 : idx_q + 4'd1;
                ST_DUMMY: if (sh_done) idx_q <= last_dummy ? 4'd0 : idx_q + 4'd1;
                ST_DATA: if (sh_done) begin
                    resp_data[{idx_q[1:0], 3'b000} +: 8] <= sh_rx;
                    idx_q <= idx_q + 4'd1;
                    if (last_data) begin
                        cs_n       <= '1;
                        resp_valid <= 1'b1;
                        resp_err   <= 1'b0;
                    end
                end
                ST_GAP: gap_q <= gap_q - 5'd1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_rd_engine.sv
module flash_rd_engine
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_word,
    input  logic [NUM_CS-1:0] addr4_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [31:0]       req_offset,
    input  logic [1:0]        req_size,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [31:0]       resp_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);

    logic [7:0]        opcode;
    logic              accept_ok;
    logic [3:0]        n_dummy, n_addr, n_data;
    logic [4:0]        gap_cycles;
    logic [NUM_CS-1:0] cs_hot;
    logic              sh_go, sh_done;
    logic [7:0]        sh_tx, sh_rx;

    flash_rd_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
        .ctrl_word  (ctrl_word),
        .addr4_mask (addr4_mask),
        .req_cs     (req_cs),
        .req_size   (req_size),
        .opcode     (opcode),
        .accept_ok  (accept_ok),
        .n_dummy    (n_dummy),
        .n_addr     (n_addr),
        .n_data     (n_data),
        .gap_cycles (gap_cycles),
        .cs_hot     (cs_hot)
    );

    flash_rd_seq #(.NUM_CS(NUM_CS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_offset (req_offset),
        .opcode     (opcode),
        .accept_ok  (accept_ok),
        .n_dummy    (n_dummy),
        .n_addr     (n_addr),
        .n_data     (n_data),
        .gap_cycles (gap_cycles),
        .cs_hot     (cs_hot),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx),
        .req_ready  (req_ready),
        .sh_go      (sh_go),
        .sh_tx      (sh_tx),
        .cs_n       (spi_cs_n),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_data  (resp_data)
    );

    flash_rd_shifter u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

endmodule

// File: rtl/flash_rd_engine_chk.sv
module flash_rd_engine_chk #(
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_err,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n
);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n)); // R2

    AST_SELECT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(&spi_cs_n) |-> !req_ready); // R2

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (&spi_cs_n)); // R7

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk); // R9

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9

    AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&spi_cs_n) |=> (&spi_cs_n)); // R8

endmodule

bind flash_rd_engine flash_rd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n)
);

// File: tb/flash_rd_engine_tb_top.sv
module flash_rd_engine_tb_top;

    localparam int NUM_CS = 3;
    localparam int CS_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       ctrl_word = 32'd0;
    logic [NUM_CS-1:0] addr4_mask = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [CS_W-1:0]   req_cs = '0;
    logic [31:0]       req_offset = 32'd0;
    logic [1:0]        req_size = 2'd0;
    logic              resp_valid, resp_err;
    logic [31:0]       resp_data;
    logic              spi_sclk, spi_mosi;
    logic              spi_miso = 1'b0;
    logic [NUM_CS-1:0] spi_cs_n;

    always #5 clk = ~clk;

    flash_rd_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W)) dut_i (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return 8'(a[7:0] * 8'd13 + a[15:8] + (a[23:16] ^ 8'h3C) + a[31:24] * 8'd3);
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [7:0] op, input logic [1:0] mode,
                                            input logic [2:0] dum, input logic [3:0] gapf);
        return {4'd0, gapf, op, 1'b0, dum[2], 6'd0, dum[1:0], 4'd0, mode};
    endfunction

    // ---------------- flash model ----------------
    int          rise_cnt = 0;
    int          nbytes_seen = 0;
    int          cs_falls = 0;
    int          mdl_hdr_len = 4;
    int          mdl_naddr = 3;
    logic [7:0]  cur = 8'd0;
    logic [7:0]  cap [0:23];
    logic [31:0] cap_addr = 32'd0;
    logic [NUM_CS-1:0] cs_seen = '1;
    wire         cs_any_low = ~&spi_cs_n;

    always @(posedge cs_any_low) begin
        rise_cnt    = 0;
        nbytes_seen = 0;
        spi_miso    = 1'b0;
        cs_seen     = spi_cs_n;
        cs_falls++;
    end

    always @(posedge spi_sclk) begin
        cur = {cur[6:0], spi_mosi};
        rise_cnt++;
        if (rise_cnt % 8 == 0) begin
            if (nbytes_seen < 24) cap[nbytes_seen] = cur;
            nbytes_seen++;
            if (nbytes_seen == 1 + mdl_naddr)
                cap_addr = (mdl_naddr == 4) ? {cap[1], cap[2], cap[3], cap[4]}
                                            : {8'd0, cap[1], cap[2], cap[3]};
        end
    end

    always @(negedge spi_sclk) begin
        if (cs_any_low && rise_cnt >= mdl_hdr_len * 8) begin
            int i;
            logic [7:0] b;
            i = rise_cnt - mdl_hdr_len * 8;
            b = mem_byte(cap_addr + 32'(i / 8));
            spi_miso = b[7 - (i % 8)];
        end
    end

    // chip-select high run length, sampled away from the clock edge
    int hi_run = 0;
    int last_gap = 0;
    always @(negedge clk) begin
        if (&spi_cs_n) hi_run++;
        else if (hi_run != 0) begin
            last_gap = hi_run;
            hi_run = 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] data;
        logic        err;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(resp_data == e.data, e.req, "resp_data", resp_data, e.data);
                chk(resp_err == e.err, e.req, "resp_err", resp_err, e.err);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic do_read(input int cs, input logic [31:0] ctrl, input logic [NUM_CS-1:0] mask,
                           input logic [31:0] off, input logic [1:0] sz, input string req);
        int          nd, na, nb, hl, falls0;
        logic [1:0]  mode;
        bit          bad_req;
        logic [7:0]  hdr [0:11];
        logic [31:0] a_eff;
        exp_t        e;
        mode    = ctrl[1:0];
        bad_req = (mode > 2'd1) || (cs >= NUM_CS);
        nd      = (mode == 2'd1) ? int'({ctrl[14], ctrl[7:6]}) : 0;
        na      = (cs < NUM_CS && mask[cs]) ? 4 : 3;
        nb      = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a_eff   = (na == 4) ? off : {8'd0, off[23:0]};
        hl      = 1 + na + nd;
        hdr[0]  = ctrl[23:16];
        for (int k = 0; k < na; k++) hdr[1 + k] = 8'(a_eff >> (8 * (na - 1 - k)));
        for (int k = 0; k < nd; k++) hdr[1 + na + k] = 8'hFF;
        e.data = 32'd0;
        e.err  = bad_req;
        e.req  = req;
        if (!bad_req)
            for (int k = 0; k < nb; k++) e.data[8 * k +: 8] = mem_byte(a_eff + 32'(k));
        mdl_naddr   = na;
        mdl_hdr_len = hl;
        falls0      = cs_falls;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ctrl_word  = ctrl;
        addr4_mask = mask;
        req_cs     = CS_W'(cs);
        req_offset = off;
        req_size   = sz;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        if (bad_req) begin
            chk(cs_falls == falls0, req, "chip select lowered on rejected request", cs_falls - falls0, 0);
        end else begin
            chk(cs_seen == ~(NUM_CS'(1) << cs), req, "selected line", cs_seen, ~(NUM_CS'(1) << cs));
            chk(nbytes_seen == hl + nb, req, "bytes on the wire", nbytes_seen, hl + nb);
            for (int k = 0; k < hl; k++)
                chk(cap[k] == hdr[k], req, $sformatf("header byte %0d", k), cap[k], hdr[k]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_cs_n == '1, "R1", "cs_n in reset", spi_cs_n, 3'b111);
        chk(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        chk(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // R2 R6: plain read, 3-byte address, 4 bytes
        do_read(0, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd15), 3'b000, 32'h0012_3456, 2'd2, "R2");
        // R5: 4-byte address on cs1, 1 byte
        do_read(1, mk_ctrl(8'h13, 2'd0, 3'd0, 4'd15), 3'b010, 32'hA1B2_C3D4, 2'd0, "R5");
        // R5: other selects wide, cs0 narrow, upper offset bits ignored, 2 bytes
        do_read(0, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd15), 3'b110, 32'hFF00_AB12, 2'd1, "R5");
        // R4: fast read with 5 dummies on cs2, 4-byte address
        do_read(2, mk_ctrl(8'h0C, 2'd1, 3'd5, 4'd15), 3'b100, 32'h0102_0304, 2'd2, "R4");
        // R4: fast read with 1 dummy, 2 bytes
        do_read(0, mk_ctrl(8'h0B, 2'd1, 3'd1, 4'd15), 3'b000, 32'h0000_7F00, 2'd1, "R4");
        // R4: fast read with dummy count zero
        do_read(1, mk_ctrl(8'h0B, 2'd1, 3'd0, 4'd15), 3'b000, 32'h0055_0001, 2'd0, "R4");
        // R3: plain read ignores a non-zero dummy field
        do_read(1, mk_ctrl(8'h03, 2'd0, 3'd7, 4'd15), 3'b000, 32'h0033_4455, 2'd2, "R3");
        // R6: size code 3 reads four bytes
        do_read(2, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd15), 3'b000, 32'h00FF_FFFE, 2'd3, "R6");
        // R7: rejected modes and out-of-range chip select
        do_read(0, mk_ctrl(8'h02, 2'd2, 3'd0, 4'd15), 3'b000, 32'h0000_0010, 2'd2, "R7");
        do_read(1, mk_ctrl(8'h9F, 2'd3, 3'd0, 4'd15), 3'b000, 32'h0000_0020, 2'd2, "R7");
        do_read(3, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd15), 3'b000, 32'h0000_0030, 2'd2, "R7");

        // R8: gap of 8 cycles, then back-to-back read
        do_read(0, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd8), 3'b000, 32'h0000_0100, 2'd0, "R8");
        do_read(0, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd8), 3'b000, 32'h0000_0200, 2'd0, "R8");
        chk(last_gap >= 8, "R8", "cs high cycles (gap 8)", last_gap, 8);
        // R8: gap field 0 gives 16 cycles
        do_read(1, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd0), 3'b000, 32'h0000_0300, 2'd0, "R8");
        do_read(1, mk_ctrl(8'h03, 2'd0, 3'd0, 4'd0), 3'b000, 32'h0000_0400, 2'd0, "R8");
        chk(last_gap >= 16, "R8", "cs high cycles (gap 16)", last_gap, 16);

        // R9: idle link after all traffic
        repeat (20) @(negedge clk);
        chk(spi_sclk == 1'b0 && spi_cs_n == '1, "R9", "idle link", {spi_sclk, spi_cs_n}, 4'b0111);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule